// File: doc/BRIEF.md
# Plug and Play Card State Controller

This block is the card-side sequencer of an ISA-style Plug and Play adapter. It watches host writes to the address port and the write-data port, and host read strobes on the read-data port. After reset the card is locked: it only scans address-port writes for a fixed 32-byte unlock sequence. When the sequence completes, the card begins to answer wake commands. A wake command carries a Card Select Number (CSN). When that number matches the card's own CSN, the card enters isolation if its CSN is still zero, and configuration otherwise.

The block keeps the CSN register and the currently selected register index. It presents its state to neighbouring logic as a 2-bit code, so that the serial-identifier arbitration, the resource-data storage and the configuration registers can gate their own accesses. The arbitration logic reports a lost bit contest on a single strobe input. Read and write accesses to the data ports are forwarded as qualified enables only when the card is unlocked.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset, the state code is 0 (locked), the CSN is 0 and the register index is 0.
- R2: The unlock sequence is 32 bytes. The first byte is 0x6A, and each later byte b' is {b[6:0], b[7]^b[5]^b[4]^b[3]} of the byte b before it. The state becomes 1 (sleep) one clock after the 32nd matching address-port write, and stays 0 after only 31 matching writes.
- R3: An address-port write that differs from the expected unlock byte restarts matching at byte 0x6A. The differing byte is not itself re-examined.
- R4: While locked, write-data and read strobes have no effect: rd_en_o and wr_en_o stay low, and the state and CSN do not change.
- R5: When unlocked, an address-port write loads the register index one clock later, and rd_en_o and wr_en_o follow their strobes combinationally.
- R6: A data write to index 0x03 (wake) whose argument equals the stored CSN moves the card to state 2 (isolation) if the CSN is 0, and to state 3 (configuration) otherwise.
- R7: A wake whose argument differs from the stored CSN moves the card to state 1 (sleep). The card stays in sleep until a matching wake arrives.
- R8: A non-zero data write to index 0x06 while in isolation stores the CSN and moves the card to configuration. A zero value, or any such write outside isolation, is ignored.
- R9: iso_lost_i in isolation returns the card to sleep. It takes precedence over a CSN write in the same cycle, and has no effect in other states.
- R10: Data writes to any other index leave the state and the CSN unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_wr_i | input | 1 | Address-port write strobe |
| addr_data_i | input | 8 | Address-port write data |
| wdata_wr_i | input | 1 | Write-data port strobe |
| wdata_i | input | 8 | Write-data port data |
| rdata_rd_i | input | 1 | Read-data port strobe |
| iso_lost_i | input | 1 | Isolation arbitration lost, one-cycle pulse |
| state_o | output | 2 | 0 locked, 1 sleep, 2 isolation, 3 configuration |
| csn_o | output | 8 | Stored Card Select Number |
| index_o | output | 8 | Selected register index |
| rd_en_o | output | 1 | Qualified read access for neighbour registers |
| wr_en_o | output | 1 | Qualified write access for neighbour registers |

## Verification
The assertions assume that every strobe lasts one clock, is synchronous to clk, and carries stable data in the cycle it is high. They also assume that iso_lost_i is raised only as a pulse from the arbitration logic. The stimulus raises each strobe for exactly one cycle, between falling edges. A lost-arbitration pulse may share its cycle with a CSN write, but never with a wake command. The unlock bytes come from an independent model of the sequence. Deliberate mismatches use 0x00, a value the sequence never produces.

// File: rtl/pnp_pkg.sv
package pnp_pkg;

  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_ISO   = 2'd2,
    ST_CFG   = 2'd3
  } pnp_state_e;

endpackage

// File: rtl/pnp_key_match.sv
module pnp_key_match #(
  parameter int              DW      = 8,
  parameter int              KEY_LEN = 32,
  parameter logic [DW-1:0]   SEED    = 8'h6A,
  parameter logic [DW-1:0]   TAPS    = 8'hB8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] byte_i,
  output logic          done_o
);

  localparam int            PW   = $clog2(KEY_LEN);
  localparam logic [PW-1:0] LAST = PW'(KEY_LEN - 1);

  logic [DW-1:0] exp_q, exp_d;
  logic [PW-1:0] pos_q, pos_d;
  logic          hit;
  logic          ld;

  assign hit = (byte_i == exp_q);
  assign ld  = !en_i || wr_i;

  always_comb begin
    exp_d  = exp_q;
    pos_d  = pos_q;
    done_o = 1'b0;
    if (!en_i) begin
      exp_d = SEED;
      pos_d = '0;
    end else if (wr_i) begin
      if (hit && (pos_q == LAST)) begin
        done_o = 1'b1;
        exp_d  = SEED;
        pos_d  = '0;
      end else if (hit) begin
        exp_d = {exp_q[DW-2:0], ^(exp_q & TAPS)};
        pos_d = pos_q + 1'b1;
      end else begin
        exp_d = SEED;
        pos_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= SEED;
      pos_q <= '0;
    end else if (ld) begin
      exp_q <= exp_d;
      pos_q <= pos_d;
    end
  end

  // R3
  restart_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && wr_i && !hit) |=> (pos_q == '0 && exp_q == SEED));

  // R2
  advance_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && wr_i && hit && pos_q != LAST) |=> (pos_q == PW'($past(pos_q) + 1'b1)));

endmodule

// File: rtl/pnp_cmd_decode.sv
module pnp_cmd_decode #(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] IDX_WAKE = 8'h03,
  parameter logic [DW-1:0] IDX_CSN  = 8'h06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          addr_wr_i,
  input  logic [DW-1:0] addr_i,
  input  logic          wdata_wr_i,
  input  logic          rdata_rd_i,
  output logic [DW-1:0] index_o,
  output logic          wake_o,
  output logic          csn_set_o,
  output logic          rd_en_o,
  output logic          wr_en_o
);

  logic [DW-1:0] idx_q, idx_d;
  logic          idx_ld;

  assign idx_ld = active_i && addr_wr_i;

  always_comb begin
    idx_d = idx_q;
    if (idx_ld) idx_d = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_ld) idx_q <= idx_d;
  end

  always_comb begin
    wr_en_o   = active_i && wdata_wr_i;
    rd_en_o   = active_i && rdata_rd_i;
    wake_o    = wr_en_o && (idx_q == IDX_WAKE);
    csn_set_o = wr_en_o && (idx_q == IDX_CSN);
  end

  assign index_o = idx_q;

  // R5
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && addr_wr_i) |=> (index_o == $past(addr_i)));

  // R4
  locked_index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> $stable(index_o));

endmodule

// File: rtl/pnp_state_fsm.sv
module pnp_state_fsm
  import pnp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_done_i,
  input  logic          wake_i,
  input  logic          csn_set_i,
  input  logic [DW-1:0] data_i,
  input  logic          iso_lost_i,
  output pnp_state_e    state_o,
  output logic [DW-1:0] csn_o
);

  pnp_state_e    st_q, st_d;
  logic [DW-1:0] csn_q, csn_d;
  logic          csn_ld;

  always_comb begin
    st_d   = st_q;
    csn_d  = csn_q;
    csn_ld = 1'b0;
    if (st_q == ST_LOCK) begin
      if (key_done_i) st_d = ST_SLEEP;
    end else if (wake_i) begin
      if (data_i == csn_q) st_d = (csn_q == '0) ? ST_ISO : ST_CFG;
      else                 st_d = ST_SLEEP;
    end else if (st_q == ST_ISO) begin
      if (iso_lost_i) begin
        st_d = ST_SLEEP;
      end else if (csn_set_i && (data_i != '0)) begin
        csn_d  = data_i;
        csn_ld = 1'b1;
        st_d   = ST_CFG;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LOCK;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csn_q <= '0;
    else if (csn_ld) csn_q <= csn_d;
  end

  assign state_o = st_q;
  assign csn_o   = csn_q;

  // R2
  unlock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && $past(st_q) == ST_LOCK) |-> $past(key_done_i));

  // R6
  cfg_has_csn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CFG) |-> (csn_q != '0));

  // R7
  wake_miss_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_i && st_q != ST_LOCK && data_i != csn_q) |=> (st_q == ST_SLEEP));

  // R8
  csn_only_in_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_q != $past(csn_q)) |-> ($past(st_q) == ST_ISO && st_q == ST_CFG));

  // R9
  lost_to_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ISO && iso_lost_i && !wake_i) |=> (st_q == ST_SLEEP));

endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_pkg::*;
#(
  parameter int        DW       = 8,
  parameter int        KEY_LEN  = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A,
  parameter logic [7:0] KEY_TAPS = 8'hB8,
  parameter logic [7:0] IDX_WAKE = 8'h03,
  parameter logic [7:0] IDX_CSN  = 8'h06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr_i,
  input  logic [DW-1:0] addr_data_i,
  input  logic          wdata_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rdata_rd_i,
  input  logic          iso_lost_i,
  output logic [1:0]    state_o,
  output logic [DW-1:0] csn_o,
  output logic [DW-1:0] index_o,
  output logic          rd_en_o,
  output logic          wr_en_o
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  pnp_state_e state;
  logic       key_done;
  logic       wake;
  logic       csn_set;
  logic       active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign active = (state != ST_LOCK);

  pnp_key_match #(
    .DW(DW), .KEY_LEN(KEY_LEN), .SEED(DW'(KEY_SEED)), .TAPS(DW'(KEY_TAPS))
  ) u_key (
    .clk(clk), .rst_n(rst_core_n), .en_i(!active),
    .wr_i(addr_wr_i), .byte_i(addr_data_i), .done_o(key_done)
  );

  pnp_cmd_decode #(
    .DW(DW), .IDX_WAKE(DW'(IDX_WAKE)), .IDX_CSN(DW'(IDX_CSN))
  ) u_dec (
    .clk(clk), .rst_n(rst_core_n), .active_i(active),
    .addr_wr_i(addr_wr_i), .addr_i(addr_data_i),
    .wdata_wr_i(wdata_wr_i), .rdata_rd_i(rdata_rd_i),
    .index_o(index_o), .wake_o(wake), .csn_set_o(csn_set),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o)
  );

  pnp_state_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .key_done_i(key_done),
    .wake_i(wake), .csn_set_i(csn_set), .data_i(wdata_i),
    .iso_lost_i(iso_lost_i), .state_o(state), .csn_o(csn_o)
  );

  assign state_o = state;

  // R4
  locked_no_access_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_o == 2'd0) |-> (!rd_en_o && !wr_en_o));

endmodule

// File: tb/sim_pnp_card_ctrl.sv
module sim_pnp_card_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_wr = 1'b0, wdata_wr = 1'b0, rdata_rd = 1'b0, iso_lost = 1'b0;
  logic [7:0] addr_data = '0, wdata = '0;
  logic [1:0] state;
  logic [7:0] csn, index;
  logic       rd_en, wr_en;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pnp_card_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .addr_wr_i(addr_wr), .addr_data_i(addr_data),
    .wdata_wr_i(wdata_wr), .wdata_i(wdata), .rdata_rd_i(rdata_rd),
    .iso_lost_i(iso_lost), .state_o(state), .csn_o(csn), .index_o(index),
    .rd_en_o(rd_en), .wr_en_o(wr_en)
  );

  // ops: 0 address write, 1 data write, 2 lost pulse
  // fields: {op[19:18], data[17:10], exp_state[9:8], exp_csn[7:0]}
  localparam logic [19:0] VEC [21] = '{
    {2'd0, 8'h03, 2'd1, 8'h00},  // R5 index to wake
    {2'd1, 8'h05, 2'd1, 8'h00},  // R7 wake miss
    {2'd1, 8'h00, 2'd2, 8'h00},  // R6 wake hit, csn zero
    {2'd0, 8'h06, 2'd2, 8'h00},  // R5
    {2'd1, 8'h00, 2'd2, 8'h00},  // R8 zero csn ignored
    {2'd2, 8'h00, 2'd1, 8'h00},  // R9 lost
    {2'd0, 8'h03, 2'd1, 8'h00},
    {2'd1, 8'h00, 2'd2, 8'h00},  // R6
    {2'd0, 8'h06, 2'd2, 8'h00},
    {2'd1, 8'h07, 2'd3, 8'h07},  // R8 csn assigned
    {2'd0, 8'h05, 2'd3, 8'h07},
    {2'd1, 8'h09, 2'd3, 8'h07},  // R10 other index
    {2'd0, 8'h03, 2'd3, 8'h07},
    {2'd1, 8'h07, 2'd3, 8'h07},  // R6 nonzero csn wake
    {2'd1, 8'h02, 2'd1, 8'h07},  // R7 miss to sleep
    {2'd1, 8'h00, 2'd1, 8'h07},  // R7 stays asleep
    {2'd2, 8'h00, 2'd1, 8'h07},  // R9 ignored outside isolation
    {2'd0, 8'h06, 2'd1, 8'h07},
    {2'd1, 8'h09, 2'd1, 8'h07},  // R8 ignored outside isolation
    {2'd0, 8'h03, 2'd1, 8'h07},
    {2'd1, 8'h07, 2'd3, 8'h07}   // R6
  };

  function automatic logic [7:0] key_byte(input int n);
    logic [7:0] b = 8'h6A;
    for (int i = 0; i < n; i++) b = {b[6:0], b[7] ^ b[5] ^ b[4] ^ b[3]};
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addr_w(input logic [7:0] b);
    addr_wr = 1'b1; addr_data = b;
    @(negedge clk);
    addr_wr = 1'b0;
  endtask

  task automatic data_w(input logic [7:0] b);
    wdata_wr = 1'b1; wdata = b;
    @(negedge clk);
    wdata_wr = 1'b0;
  endtask

  task automatic lost_p();
    iso_lost = 1'b1;
    @(negedge clk);
    iso_lost = 1'b0;
  endtask

  task automatic send_key(input int from, input int upto);
    for (int i = from; i < upto; i++) addr_w(key_byte(i));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset values
    chk("R1 state", 32'(state), 32'd0);
    chk("R1 csn", 32'(csn), 32'd0);
    chk("R1 index", 32'(index), 32'd0);

    // R4 locked: data and read strobes are ignored
    addr_w(8'h03);
    wdata_wr = 1'b1; wdata = 8'h00; rdata_rd = 1'b1;
    #1;
    chk("R4 wr_en", 32'(wr_en), 32'd0);
    chk("R4 rd_en", 32'(rd_en), 32'd0);
    @(negedge clk);
    wdata_wr = 1'b0; rdata_rd = 1'b0;
    chk("R4 state", 32'(state), 32'd0);
    chk("R4 index", 32'(index), 32'd0);

    // R3 a miss mid-sequence restarts matching
    send_key(0, 10);
    addr_w(8'h00);
    send_key(10, 32);
    chk("R3 state after broken key", 32'(state), 32'd0);

    // R2 31 bytes are not enough
    addr_w(8'h00);
    send_key(0, 31);
    chk("R2 state after 31", 32'(state), 32'd0);
    addr_w(8'h00);
    send_key(0, 32);
    chk("R2 state after 32", 32'(state), 32'd1);

    // R5 qualified accesses when unlocked
    rdata_rd = 1'b1;
    #1;
    chk("R5 rd_en", 32'(rd_en), 32'd1);
    @(negedge clk);
    rdata_rd = 1'b0;
    wdata_wr = 1'b1; wdata = 8'h44;
    #1;
    chk("R5 wr_en", 32'(wr_en), 32'd1);
    @(negedge clk);
    wdata_wr = 1'b0;
    chk("R10 state after index 0 write", 32'(state), 32'd1);

    // table walk
    for (int i = 0; i < 21; i++) begin
      case (VEC[i][19:18])
        2'd0:    addr_w(VEC[i][17:10]);
        2'd1:    data_w(VEC[i][17:10]);
        default: lost_p();
      endcase
      chk($sformatf("vec%0d state", i), 32'(state), 32'(VEC[i][9:8]));
      chk($sformatf("vec%0d csn", i), 32'(csn), 32'(VEC[i][7:0]));
      if (VEC[i][19:18] == 2'd0)
        chk($sformatf("R5 vec%0d index", i), 32'(index), 32'(VEC[i][17:10]));
    end

    // R9 lost takes precedence over a same-cycle csn write
    do_reset();
    chk("R1 csn after second reset", 32'(csn), 32'd0);
    send_key(0, 32);
    addr_w(8'h03);
    data_w(8'h00);
    chk("R6 isolation", 32'(state), 32'd2);
    addr_w(8'h06);
    wdata_wr = 1'b1; wdata = 8'h05; iso_lost = 1'b1;
    @(negedge clk);
    wdata_wr = 1'b0; iso_lost = 1'b0;
    chk("R9 priority state", 32'(state), 32'd1);
    chk("R9 priority csn", 32'(csn), 32'd0);

    summary();
  end

endmodule